// File: doc/BRIEF.md
# Toggle-Capable GPIO Port

This block is an eight-pin general-purpose I/O port that sits behind a small register bus. Software sees three registers: a pin-level register, a direction register and an output-level register. Pin levels are read through a two-stage synchroniser. Writing ones to the pin-level register inverts the matching output bits, so a single bus write can flip any group of pins without a read-modify-write.

Each pad is modelled as three separate signals: output enable, output value and pull-up enable. A pin with direction 0 and output bit 1 gets its pull-up. A single global pull-down-of-pull-ups input (`pu_disable`) turns every pull-up off. A peripheral can take over any pin on its own through a per-pin override of output enable and output value. The other pins keep following the registers.

The register bus is a plain write strobe with a combinational read. There is no stream data path, so there is no valid/ready handshake and no back-pressure. Every write takes effect at the next clock edge.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction and output registers read 0, `pad_oe` is 0 and `pad_pu` is 0.
- R2: A write to address 1 (direction) stores `wr_data`. Address 1 then reads back that value. With no override, `pad_oe` equals it.
- R3: A write to address 2 (output) stores `wr_data`. Address 2 then reads back that value. With no override, `pad_out` equals it.
- R4: A write to address 0 (pin level) replaces the output register with its old value XOR `wr_data`. Zero bits leave their pins unchanged, and the direction register is not affected.
- R5: A read of address 0 returns `pad_in` as it was two rising clock edges earlier, whatever the direction bits are.
- R6: `pad_pu[i]` equals (direction bit i is 0) AND (output bit i is 1) AND (`pu_disable` is 0).
- R7: For a pin with `alt_en[i]` set, `pad_oe[i]` and `pad_out[i]` take `alt_oe[i]` and `alt_out[i]`. The pull-up still follows R6.
- R8: An override on one pin leaves the `pad_oe`, `pad_out` and `pad_pu` of every other pin equal to its register-driven value.
- R9: Address 3 is unmapped. It reads as 0, and writes to it change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address (0 pin level, 1 direction, 2 output, 3 unmapped) |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| pu_disable | input | 1 | Global pull-up disable |
| alt_en | input | 8 | Per-pin peripheral override enable |
| alt_oe | input | 8 | Override output enable |
| alt_out | input | 8 | Override output value |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output value |
| pad_pu | output | 8 | Pad pull-up enable |

## Verification
The direction and output registers are swept through all 256 values. This separates correct per-bit storage from stuck or swapped bits on the register path and the pad path. The toggle write is tried with every 8-bit mask against many starting output values, including the all-zero mask, so a plain store, a set-only update or a mask that leaks into direction each show up as a mismatch. Pull-ups are swept over 1024 direction/output pairs with the global disable both low and high. Pad inputs are stepped through all values and checked one edge and two edges later, which catches both a missing and an extra synchroniser stage. Overrides are swept over all 256 enable masks and then tried one pin at a time to show that they stay confined to their own pins.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PIN  = 2'd0,
    REG_DIR  = 2'd1,
    REG_OUT  = 2'd2,
    REG_NONE = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      logic [1:0] age;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age <= '0;
        else if (age != 2'd2) age <= age + 2'd1;
      end
      // R5: the readback lags the pad by exactly two edges
      a_r5_two_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (dout == $past(din, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  out_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (wr_en) begin
      case (addr)
        REG_DIR: dir_q <= wr_data;
        REG_OUT: out_q <= wr_data;
        REG_PIN: out_q <= out_q ^ wr_data;
        default: ;
      endcase
    end
  end

  // R4: a pin-address write inverts exactly the masked output bits
  a_r4_toggle_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_PIN) |=> (out_q == ($past(out_q) ^ $past(wr_data))));
  // R4: a pin-address write leaves direction alone
  a_r4_dir_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_PIN) |=> $stable(dir_q));
  // R9: unmapped writes change nothing
  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_NONE) |=> ($stable(dir_q) && $stable(out_q)));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] out_q,
  input  logic             pu_disable,
  input  logic [WIDTH-1:0] alt_en,
  input  logic [WIDTH-1:0] alt_oe,
  input  logic [WIDTH-1:0] alt_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pu
);
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign pad_oe[i]  = alt_en[i] ? alt_oe[i]  : dir_q[i];
      assign pad_out[i] = alt_en[i] ? alt_out[i] : out_q[i];
      assign pad_pu[i]  = ~dir_q[i] & out_q[i] & ~pu_disable;
    end
  endgenerate

  // R6: the global disable removes every pull-up
  a_r6_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    pu_disable |-> (pad_pu == '0));
  // R6: no pull-up on a pin the registers configure as output
  a_r6_no_pull_on_output: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & dir_q) == '0));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  rd_data,
  input  logic              pu_disable,
  input  logic [WIDTH-1:0]  alt_en,
  input  logic [WIDTH-1:0]  alt_oe,
  input  logic [WIDTH-1:0]  alt_out,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_pu
);
  logic [WIDTH-1:0] dir_q, out_q, pin_s;

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .dir_q(dir_q), .out_q(out_q)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pin_s)
  );

  gpio_pad_mux #(.WIDTH(WIDTH)) u_mux (
    .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .out_q(out_q),
    .pu_disable(pu_disable), .alt_en(alt_en), .alt_oe(alt_oe),
    .alt_out(alt_out), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  always_comb begin
    case (addr)
      REG_PIN: rd_data = pin_s;
      REG_DIR: rd_data = dir_q;
      REG_OUT: rd_data = out_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       pu_disable = 1'b0;
  logic [7:0] alt_en = 8'h00, alt_oe = 8'h00, alt_out = 8'h00;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] pad_oe, pad_out, pad_pu;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  gpio_port u_gpio_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pu_disable(pu_disable), .alt_en(alt_en),
    .alt_oe(alt_oe), .alt_out(alt_out), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    bus_rd(2'd1, v); check("R1 dir", v, 8'h00);
    bus_rd(2'd2, v); check("R1 out", v, 8'h00);
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_pu", pad_pu, 8'h00);

    // R2 and R3: full value sweeps of direction and output
    for (int k = 0; k < 256; k++) begin
      bus_wr(2'd1, 8'(k));
      bus_wr(2'd2, 8'(255 - k));
      bus_rd(2'd1, v); check("R2 dir readback", v, 8'(k));
      check("R2 pad_oe", pad_oe, 8'(k));
      bus_rd(2'd2, v); check("R3 out readback", v, 8'(255 - k));
      check("R3 pad_out", pad_out, 8'(255 - k));
    end

    // R6: pull-up logic over direction/output pairs, disable low and high
    for (int d = 0; d < 256; d++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] dv;
        dv = 8'((d * 37 + k * 91) & 255);
        bus_wr(2'd1, 8'(d));
        bus_wr(2'd2, dv);
        pu_disable = 1'b0; #1;
        check("R6 pull enabled", pad_pu, ~8'(d) & dv);
        pu_disable = 1'b1; #1;
        check("R6 pull disabled", pad_pu, 8'h00);
        pu_disable = 1'b0;
      end
    end

    // R4: every toggle mask against a spread of starting values
    for (int b = 0; b < 256; b += 15) begin
      for (int m = 0; m < 256; m++) begin
        bus_wr(2'd1, 8'hA5);
        bus_wr(2'd2, 8'(b));
        bus_wr(2'd0, 8'(m));
        bus_rd(2'd2, v); check("R4 toggle out", v, 8'(b) ^ 8'(m));
        bus_rd(2'd1, v); check("R4 dir kept", v, 8'hA5);
      end
    end

    // R5: synchronised readback, as outputs and as inputs
    for (int dd = 0; dd < 2; dd++) begin
      bus_wr(2'd1, dd == 0 ? 8'hFF : 8'h00);
      bus_wr(2'd2, 8'h00);
      addr = 2'd0;
      repeat (3) @(negedge clk);
      prev = pad_in;
      for (int p = 0; p < 256; p++) begin
        pad_in = 8'(p ^ (dd * 8'h3C));
        @(negedge clk);
        bus_rd(2'd0, v); check("R5 one edge old", v, prev);
        @(negedge clk);
        bus_rd(2'd0, v); check("R5 two edges new", v, pad_in);
        prev = pad_in;
      end
    end

    // R7: override masks
    bus_wr(2'd1, 8'h0F);
    bus_wr(2'd2, 8'h33);
    for (int e = 0; e < 256; e++) begin
      alt_en  = 8'(e);
      alt_oe  = ~8'(e) ^ 8'h5A;
      alt_out = 8'((e * 3) & 255);
      #1;
      check("R7 pad_oe", pad_oe, (alt_en & alt_oe) | (~alt_en & 8'h0F));
      check("R7 pad_out", pad_out, (alt_en & alt_out) | (~alt_en & 8'h33));
      check("R7 pad_pu", pad_pu, 8'h30);
    end

    // R8: one overridden pin at a time, opposite to register values
    for (int i = 0; i < 8; i++) begin
      logic [7:0] msk;
      msk = 8'(1 << i);
      alt_en = msk; alt_oe = ~8'h0F; alt_out = ~8'h33;
      #1;
      check("R8 others oe", pad_oe & ~msk, 8'h0F & ~msk);
      check("R8 others out", pad_out & ~msk, 8'h33 & ~msk);
      check("R8 others pu", pad_pu & ~msk, 8'h30 & ~msk);
    end
    alt_en = 8'h00;

    // R9: unmapped address
    pad_in = 8'hC3;
    bus_wr(2'd3, 8'hFF);
    bus_rd(2'd3, v); check("R9 reads zero", v, 8'h00);
    bus_rd(2'd1, v); check("R9 dir kept", v, 8'h0F);
    bus_rd(2'd2, v); check("R9 out kept", v, 8'h33);

    finish_run();
  end
endmodule